// File: doc/BRIEF.md
# Pseudo-SRAM Nonvolatile Memory Control

This block is the clocked control core of a word-wide nonvolatile memory that presents an asynchronous, SRAM-like pin set. Active-low pins for chip select, write strobe, output enable, sleep request and two byte-lane selects arrive with no timing relation to the system clock. They pass through two-flop synchronizers together with the address and write data. All strobe edges are found on the synchronized copies.

A write opens when the write strobe falls with the chip selected. The data and byte selects seen just before the first of the two strobes rises are then committed to a register array. The array keeps its contents through sleep, which models retention. While the chip is selected and the write strobe is high, the block reads the word at the current address, so a new address starts a new read. The read word is shown on a separate output bus, and a per-lane enable takes the place of a bidirectional bus. A mode output reports power-up, standby, active, precharge and sleep. A low sleep pin overrides every other pin.

Top module: `psram_nv_ctrl`

## Requirements
- R1: A pin change is sampled on one rising clock edge. Its effect on `lane_oe`, `dout` and `mode` appears on the second rising edge after that one, so all three outputs have the same three-edge latency.
- R2: `mode` encodes 0 power-up, 1 standby, 2 active, 3 precharge, 4 sleep. Reset gives power-up, which lasts one cycle and then goes to standby. Standby goes to active when chip select is low. Active goes to precharge when chip select rises.
- R3: While the synchronized sleep pin is low, `mode` is 4, `lane_oe` is 0, and no strobe activity writes the array.
- R4: In a write-strobe-controlled write, the write strobe falls while chip select is low and then rises before chip select. The word is stored when the write strobe rises.
- R5: In a chip-select-controlled write, both strobes are low and chip select rises first. The word is stored when chip select rises, and the later rise of the write strobe stores nothing more.
- R6: A low lower select writes bits 7:0, and a low upper select writes bits 15:8. With both selects high, no bit of the word changes.
- R7: `lane_oe[0]` is high only when the block is selected and awake, the write strobe is high, output enable is low and the lower select is low. `lane_oe[1]` follows the same rule with the upper select.
- R8: While output enable is high, `lane_oe` is 0.
- R9: A change of address while the chip is selected with the write strobe high updates `dout` to the word at the new address, with no strobe toggle needed.
- R10: The array index is the address modulo `DEPTH`, so addresses that differ by a multiple of `DEPTH` reach the same word.
- R11: Array contents are unchanged after a pass through sleep.
- R12: Precharge lasts exactly one cycle. It then goes to active if chip select is low again, or to standby otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| zz_n | input | 1 | Sleep request, active low |
| lb_n | input | 1 | Lower byte select, active low |
| ub_n | input | 1 | Upper byte select, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| lane_oe | output | 2 | Per-lane drive enable, bit 0 for bits 7:0 |
| mode | output | 3 | Operating mode code |

## Verification
The bench builds the block with `DEPTH` 16 and keeps the full 18-bit address. An address of 19 therefore aliases word 3, and a write to 21 lands on word 5, which exercises the modulo indexing within a short run. At the default depth of 1024 words, the same aliasing would need addresses far beyond the ones the bench uses. The small array also lets the reference model track every word, so retention across sleep and byte-lane merges are compared exactly.

// File: rtl/psram_nv_ctrl.sv
module psram_nv_ctrl #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              zz_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        lane_oe,
  output logic [2:0]        mode
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LANE_W = DATA_W / 2;
  localparam int ZZ = 0, CE = 1, WE = 2, OE = 3, LB = 4, UB = 5;

  typedef enum logic [2:0] {
    M_PWRUP = 3'd0, M_STBY = 3'd1, M_ACT = 3'd2, M_PRE = 3'd3, M_SLEEP = 3'd4
  } mode_t;

  logic [5:0]        ctl_s1, ctl_s2;
  logic [ADDR_W-1:0] addr_s1, addr_s2, addr_q;
  logic [DATA_W-1:0] din_s1, din_s2, din_q;
  logic              zz_q, ce_q, we_q, lb_q, ub_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  mode_t             mode_q, mode_d;

  wire zz_s = ctl_s2[ZZ];
  wire ce_s = ctl_s2[CE];
  wire we_s = ctl_s2[WE];
  wire oe_s = ctl_s2[OE];
  wire lb_s = ctl_s2[LB];
  wire ub_s = ctl_s2[UB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1  <= '1;
      ctl_s2  <= '1;
      addr_s1 <= '0;
      addr_s2 <= '0;
      din_s1  <= '0;
      din_s2  <= '0;
      {zz_q, ce_q, we_q, lb_q, ub_q} <= '1;
      addr_q  <= '0;
      din_q   <= '0;
    end else begin
      ctl_s1  <= {ub_n, lb_n, oe_n, we_n, ce_n, zz_n};
      ctl_s2  <= ctl_s1;
      addr_s1 <= addr;
      addr_s2 <= addr_s1;
      din_s1  <= din;
      din_s2  <= din_s1;
      {zz_q, ce_q, we_q, lb_q, ub_q} <= {zz_s, ce_s, we_s, lb_s, ub_s};
      addr_q  <= addr_s2;
      din_q   <= din_s2;
    end
  end

  wire             rd_go  = zz_s & ~ce_s & we_s;
  wire             commit = zz_s & zz_q & ~ce_q & ~we_q & (ce_s | we_s);
  wire [1:0]       wr_lane = {2{commit}} & ~{ub_q, lb_q};
  wire [IDX_W-1:0] rd_idx = IDX_W'(addr_s2 % ADDR_W'(DEPTH));
  wire [IDX_W-1:0] wr_idx = IDX_W'(addr_q % ADDR_W'(DEPTH));

  always_ff @(posedge clk) begin
    for (int l = 0; l < 2; l++)
      if (wr_lane[l]) mem[wr_idx][l*LANE_W +: LANE_W] <= din_q[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      lane_oe <= '0;
    end else begin
      if (rd_go) rd_q <= mem[rd_idx];
      lane_oe <= {2{rd_go & ~oe_s}} & ~{ub_s, lb_s};
    end
  end

  always_comb begin
    mode_d = M_STBY;
    if (!zz_s) mode_d = M_SLEEP;
    else begin
      case (mode_q)
        M_PWRUP, M_SLEEP: mode_d = M_STBY;
        M_STBY:           mode_d = ce_s ? M_STBY : M_ACT;
        M_ACT:            mode_d = ce_s ? M_PRE  : M_ACT;
        M_PRE:            mode_d = ce_s ? M_STBY : M_ACT;
        default:          mode_d = M_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_PWRUP;
    else        mode_q <= mode_d;
  end

  assign dout = rd_q;
  assign mode = mode_q;
endmodule

// File: rtl/psram_nv_ctrl_chk.sv
module psram_nv_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic [1:0] lane_oe,
  input logic [1:0] wr_lane,
  input logic       oe_s
);
  // R3
  sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd4 |-> lane_oe == 2'b00);

  // R3
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane != 2'b00 |-> mode != 3'd4);

  // R12
  pre_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd3 |=> mode != 3'd3);

  // R2
  pwrup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 |=> mode == 3'd1);

  // R8
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_s) |-> lane_oe == 2'b00);
endmodule

bind psram_nv_ctrl psram_nv_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .lane_oe (lane_oe),
  .wr_lane (wr_lane),
  .oe_s    (ctl_s2[3])
);

// File: tb/psram_nv_ctrl_tb.sv
`timescale 1ns/1ps
module psram_nv_ctrl_tb;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic        ce, we, oe, zz, lb, ub;
    logic [17:0] addr;
    logic [15:0] din;
  } pins_t;

  localparam pins_t IDLE = '{ce:1'b1, we:1'b1, oe:1'b1, zz:1'b1, lb:1'b1, ub:1'b1,
                             addr:18'd0, din:16'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  pins_t pin = IDLE;
  logic [15:0] dout;
  logic [1:0]  lane_oe;
  logic [2:0]  mode;

  always #2.5 clk = ~clk;

  psram_nv_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ce_n(pin.ce), .we_n(pin.we), .oe_n(pin.oe), .zz_n(pin.zz),
    .lb_n(pin.lb), .ub_n(pin.ub), .addr(pin.addr), .din(pin.din),
    .dout(dout), .lane_oe(lane_oe), .mode(mode)
  );

  // Reference model: pin history a (1 edge old), b (2), c (3)
  pins_t a = IDLE, b = IDLE, c = IDLE;
  logic [15:0] mem_m [DEPTH];
  logic [15:0] exp_rd = 16'd0;
  logic [1:0]  exp_lane = 2'b00;
  int          exp_mode = 0;
  int vectors = 0, miscompares = 0;
  bit checking = 0, done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      a = IDLE; b = IDLE; c = IDLE;
      exp_rd = 16'd0; exp_lane = 2'b00; exp_mode = 0;
    end else begin
      bit act;
      act = b.zz && !b.ce;
      if (act && b.we) exp_rd = mem_m[b.addr % DEPTH];
      exp_lane = {act && b.we && !b.oe && !b.ub, act && b.we && !b.oe && !b.lb};
      if (!b.zz) exp_mode = 4;
      else if (exp_mode == 0 || exp_mode == 4) exp_mode = 1;
      else if (exp_mode == 1) exp_mode = b.ce ? 1 : 2;
      else if (exp_mode == 2) exp_mode = b.ce ? 3 : 2;
      else exp_mode = b.ce ? 1 : 2;
      if (b.zz && c.zz && !c.ce && !c.we && (b.ce || b.we)) begin
        if (!c.lb) mem_m[c.addr % DEPTH][7:0]  = c.din[7:0];
        if (!c.ub) mem_m[c.addr % DEPTH][15:8] = c.din[15:8];
      end
      c = b; b = a; a = pin;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (mode !== exp_mode[2:0]) begin
        miscompares++;
        $display("FAIL R2 mode actual %0d expected %0d at %0t", mode, exp_mode, $time);
      end else if (lane_oe !== exp_lane) begin
        miscompares++;
        $display("FAIL R7 lane_oe actual %b expected %b at %0t", lane_oe, exp_lane, $time);
      end else if ((exp_lane[0] && dout[7:0] !== exp_rd[7:0]) ||
                   (exp_lane[1] && dout[15:8] !== exp_rd[15:8])) begin
        miscompares++;
        $display("FAIL R9 data actual %h expected %h (lanes %b) at %0t",
                 dout, exp_rd, exp_lane, $time);
      end
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    checking = 1;
    hold(4);                                            // R2 power-up then standby

    // R4: write-strobe controlled write, both lanes, addr 3
    pin.addr = 18'd3; pin.din = 16'hA5C3; pin.lb = 0; pin.ub = 0;
    pin.ce = 0; hold(4);
    pin.we = 0; hold(4);
    pin.we = 1; hold(4);
    pin.ce = 1; hold(4);                                // R12 precharge one cycle

    // R5: chip-select controlled write at addr 21 (aliases 5, R10)
    pin.addr = 18'd21; pin.din = 16'h1234;
    pin.ce = 0; pin.we = 0; hold(4);
    pin.ce = 1; hold(2);
    pin.din = 16'hFFFF; hold(2);
    pin.we = 1; hold(4);

    // R7 R1: read addr 3 with both lanes, then lower only, then upper only
    pin.addr = 18'd3; pin.ce = 0; pin.oe = 0; hold(5);
    pin.ub = 1; hold(4);
    pin.ub = 0; pin.lb = 1; hold(4);
    pin.lb = 0;
    // R8: output enable high blanks lanes
    pin.oe = 1; hold(4);
    pin.oe = 0; hold(3);
    // R9: address change while selected re-reads; R10 alias 19 -> 3
    pin.addr = 18'd5;  hold(4);
    pin.addr = 18'd19; hold(4);
    pin.ce = 1; pin.oe = 1; hold(4);

    // R6: lower-only, upper-only and no-lane writes to addr 3
    pin.ce = 0; pin.lb = 0; pin.ub = 1; pin.din = 16'h00FF;
    pin.we = 0; hold(4); pin.we = 1; hold(4);
    pin.lb = 1; pin.ub = 0; pin.din = 16'h7E00;
    pin.we = 0; hold(4); pin.we = 1; hold(4);
    pin.lb = 1; pin.ub = 1; pin.din = 16'hDEAD;
    pin.we = 0; hold(4); pin.we = 1; hold(4);
    pin.lb = 0; pin.ub = 0; pin.oe = 0; hold(5);       // read back 7EFF
    pin.oe = 1; pin.ce = 1; hold(4);

    // R3: sleep overrides a full write sequence; R11 retention
    pin.zz = 0; hold(4);
    pin.ce = 0; pin.oe = 0; hold(3);
    pin.din = 16'hBEEF; pin.we = 0; hold(4);
    pin.we = 1; hold(3); pin.ce = 1; hold(4);
    pin.zz = 1; hold(5);
    pin.ce = 0; hold(5);                                // read addr 3 still 7EFF
    pin.addr = 18'd5; hold(4);                          // addr 5 still 1234

    // R12: chip select low again right after rise goes back to active
    pin.ce = 1; hold(1); pin.ce = 0; hold(5);
    pin.ce = 1; pin.oe = 1; hold(5);

    checking = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule